// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This block is a 128-bit SIMD arithmetic unit. Each accepted request carries two byte vectors, a vector of four 32-bit accumulators and an operation code. The unit cuts the data into four 32-bit lanes. In every lane it multiplies four pairs of bytes, adds the four products together, and adds that sum to the lane's accumulator. The result comes back one cycle later from an output register, with a valid flag.

The operation code has two parts. A 2-bit pairing field says, separately for each source, whether its bytes are taken as signed or unsigned. A 1-bit flag picks wrapping or clamping on 32-bit overflow. A single valid/ready handshake at the input accepts one request per cycle, provided the result register is free or is being drained in the same cycle.

Top module: `byte_dot_acc`

## Requirements
- R1: Lane n (n = 0..3) multiplies bytes 4n..4n+3 of `src_a` with the bytes at the same positions of `src_b`. It adds the sum to `acc_in[32n+31:32n]` and writes the result to `res_data[32n+31:32n]`. No lane is affected by the bytes of any other lane.
- R2: Pairing code 2'b00 zero-extends the bytes of both sources. The accumulator is treated as an unsigned 32-bit value.
- R3: Pairing code 2'b01 zero-extends the bytes of `src_a` and sign-extends the bytes of `src_b`.
- R4: Pairing code 2'b10 sign-extends the bytes of both sources.
- R5: Pairing code 2'b11 sign-extends the bytes of `src_a` and zero-extends the bytes of `src_b`.
- R6: With `op_sat` = 0, each lane result is the low 32 bits of the exact sum, so it wraps modulo 2^32.
- R7: With `op_sat` = 1 and pairing 2'b01, 2'b10 or 2'b11, the exact sum is clamped to the range 0x80000000..0x7FFFFFFF, read as signed.
- R8: With `op_sat` = 1 and pairing 2'b00, an exact sum above 0xFFFFFFFF is replaced by 0xFFFFFFFF.
- R9: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its result is on `res_data`, with `res_valid` high, from the next edge onward.
- R10: `req_ready` is high when `res_valid` is low or `res_ready` is high. While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` hold their values.
- R11: A low `rst_n` at a rising edge clears `res_valid` and `res_data` to zero.
- R12: While `res_ready` is high, a new request is accepted on every cycle, and consecutive results appear on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| op_pair | input | 2 | Signedness pairing: 00 uu, 01 us, 10 ss, 11 su (first letter for `src_a`) |
| op_sat | input | 1 | 1 = clamp, 0 = wrap |
| src_a | input | 128 | First byte vector |
| src_b | input | 128 | Second byte vector |
| acc_in | input | 128 | Four 32-bit accumulators |
| res_valid | output | 1 | Result register holds a result |
| res_ready | input | 1 | Downstream takes the result |
| res_data | output | 128 | Four 32-bit lane results |

## Verification
The assertions check the timing on every cycle: an accepted request always yields a valid result on the next cycle, a stalled result stays put, and reset clears the register. Inside each lane they also check on every cycle that a clamped result never drops below the accumulator when the product sum is not negative. The exact lane values can only be shown by the bench's scenarios, which compare against an independent reference model. These values are the effect of each pairing on 0x80 and 0xFF bytes, the wrap against clamp results near both signed bounds and the unsigned ceiling, and the byte-to-lane mapping.

// File: rtl/bdp_pkg.sv
// Package: shared types for the packed byte dot-product accumulator.
// Assumes: pairing codes are fixed by the top-level port encoding.
package bdp_pkg;
    // Signedness pairing, first letter describes src_a, second src_b.
    typedef enum logic [1:0] {
        PAIR_UU = 2'b00,
        PAIR_US = 2'b01,
        PAIR_SS = 2'b10,
        PAIR_SU = 2'b11
    } pair_e;
endpackage

// File: rtl/bdp_sat.sv
// Module: bdp_sat
// Narrows a wide exact lane sum to the accumulator width: by wrapping,
// by a signed clamp, or by an unsigned ceiling.
// Assumes: WW > AW, and in unsigned mode the wide value is never negative.
module bdp_sat #(
    parameter int AW = 32,
    parameter int WW = 34
) (
    input  logic          sat,
    input  logic          uns,
    input  logic [WW-1:0] wide,
    output logic [AW-1:0] res
);
    localparam logic signed [WW-1:0] SMAX = {{(WW-AW+1){1'b0}}, {(AW-1){1'b1}}};
    localparam logic signed [WW-1:0] SMIN = {{(WW-AW+1){1'b1}}, {(AW-1){1'b0}}};

    // Pick the wrapped value, the clamped signed value or the unsigned ceiling.
    always_comb begin
        res = wide[AW-1:0];
        if (sat) begin
            if (uns) begin
                if (wide[WW-1:AW] != '0) res = '1;
            end else if ($signed(wide) > SMAX) begin
                res = SMAX[AW-1:0];
            end else if ($signed(wide) < SMIN) begin
                res = SMIN[AW-1:0];
            end
        end
    end
endmodule

// File: rtl/bdp_lane.sv
// Module: bdp_lane
// One lane: extends each byte according to the pairing, multiplies the
// byte pairs, adds the products, adds the sum to the accumulator, then
// wraps or clamps.
// Assumes: purely combinational; the top registers the result.
module bdp_lane
    import bdp_pkg::*;
#(
    parameter int BYTES = 4,
    parameter int BW    = 8,
    parameter int AW    = BYTES * BW
) (
    input  pair_e               pair,
    input  logic                sat,
    input  logic [BYTES*BW-1:0] a,
    input  logic [BYTES*BW-1:0] b,
    input  logic [AW-1:0]       acc,
    output logic [AW-1:0]       res
);
    localparam int PW = 2 * (BW + 1);
    localparam int SW = PW + $clog2(BYTES) + 1;
    localparam int WW = ((AW > SW) ? AW : SW) + 2;

    logic                 a_sgn, b_sgn, uns;
    logic signed [BW:0]   xa [BYTES];
    logic signed [BW:0]   xb [BYTES];
    logic signed [PW-1:0] prod [BYTES];
    logic signed [SW-1:0] psum;
    logic        [WW-1:0] acc_w, sum_w, wide;

    // Decode, for each source, whether its bytes are signed.
    always_comb begin
        a_sgn = (pair == PAIR_SS) || (pair == PAIR_SU);
        b_sgn = (pair == PAIR_SS) || (pair == PAIR_US);
        uns   = (pair == PAIR_UU);
    end

    // Extend and multiply every byte pair.
    for (genvar k = 0; k < BYTES; k++) begin : g_mul
        assign xa[k]   = {a_sgn & a[k*BW+BW-1], a[k*BW +: BW]};
        assign xb[k]   = {b_sgn & b[k*BW+BW-1], b[k*BW +: BW]};
        assign prod[k] = xa[k] * xb[k];
    end

    // Add the products at full precision.
    always_comb begin
        psum = '0;
        for (int k = 0; k < BYTES; k++) psum = psum + SW'(prod[k]);
    end

    // Add to the accumulator; it is unsigned only for the uu pairing.
    always_comb begin
        acc_w = {{(WW-AW){~uns & acc[AW-1]}}, acc};
        sum_w = {{(WW-SW){psum[SW-1]}}, psum};
        wide  = acc_w + sum_w;
    end

    bdp_sat #(.AW(AW), .WW(WW)) u_sat (
        .sat  (sat),
        .uns  (uns),
        .wide (wide),
        .res  (res)
    );

    // Clamping never moves the result below the accumulator when the sum is not negative.
    always_comb begin
        if (sat && uns) begin
            assert_uu_floor_R8: assert (res >= acc);
        end
        if (sat && !uns && !psum[SW-1]) begin
            assert_sat_no_drop_R7: assert ($signed(res) >= $signed(acc));
        end
    end
endmodule

// File: rtl/byte_dot_acc.sv
// Module: byte_dot_acc (top)
// Packed byte dot-product accumulator: LANES lanes, each built as a
// bdp_lane, feeding one registered result stage with a valid/ready handshake.
// Assumes: synchronous active-low reset; one request in flight at most.
module byte_dot_acc
    import bdp_pkg::*;
#(
    parameter int LANES = 4,
    parameter int BYTES = 4,
    parameter int BW    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [1:0]                  op_pair,
    input  logic                        op_sat,
    input  logic [LANES*BYTES*BW-1:0]   src_a,
    input  logic [LANES*BYTES*BW-1:0]   src_b,
    input  logic [LANES*BYTES*BW-1:0]   acc_in,
    output logic                        res_valid,
    input  logic                        res_ready,
    output logic [LANES*BYTES*BW-1:0]   res_data
);
    localparam int AW = BYTES * BW;
    localparam int VW = LANES * AW;

    pair_e          pair;
    logic [VW-1:0]  lane_res;
    logic           take;

    assign pair = pair_e'(op_pair);

    // One lane per 32-bit slice of the vectors.
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        bdp_lane #(.BYTES(BYTES), .BW(BW), .AW(AW)) u_lane (
            .pair (pair),
            .sat  (op_sat),
            .a    (src_a[n*AW +: AW]),
            .b    (src_b[n*AW +: AW]),
            .acc  (acc_in[n*AW +: AW]),
            .res  (lane_res[n*AW +: AW])
        );
    end

    // Accept when the result register is empty or being drained.
    always_comb begin
        req_ready = !res_valid || res_ready;
        take      = req_valid && req_ready;
    end

    // Result register: load on accept, clear valid on drain, hold on stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else if (take) begin
            res_valid <= 1'b1;
            res_data  <= lane_res;
        end else if (res_ready) begin
            res_valid <= 1'b0;
        end
    end

    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && res_data == '0));

    assert_accept_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> res_valid);

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
endmodule

// File: tb/byte_dot_acc_tb_top.sv
module byte_dot_acc_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   op_pair = 2'b00;
    logic         op_sat = 1'b0;
    logic [127:0] src_a = '0, src_b = '0, acc_in = '0;
    logic         res_valid;
    logic         res_ready = 1'b1;
    logic [127:0] res_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_dot_acc dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .op_pair(op_pair), .op_sat(op_sat), .src_a(src_a), .src_b(src_b),
        .acc_in(acc_in), .res_valid(res_valid), .res_ready(res_ready),
        .res_data(res_data)
    );

    // Reference model written from the requirements.
    function automatic logic [127:0] ref_calc(input logic [1:0] pr, input logic st,
                                              input logic [127:0] a, input logic [127:0] b,
                                              input logic [127:0] acc);
        logic [127:0] r;
        r = '0;
        for (int n = 0; n < 4; n++) begin
            longint s;
            longint av;
            longint w;
            s = 0;
            for (int k = 0; k < 4; k++) begin
                logic [7:0] ab;
                logic [7:0] bb;
                longint x;
                longint y;
                ab = a[(4*n+k)*8 +: 8];
                bb = b[(4*n+k)*8 +: 8];
                x = (pr == 2'b10 || pr == 2'b11) ? longint'($signed(ab)) : longint'(ab);
                y = (pr == 2'b01 || pr == 2'b10) ? longint'($signed(bb)) : longint'(bb);
                s = s + x * y;
            end
            av = (pr == 2'b00) ? longint'(acc[32*n +: 32]) : longint'($signed(acc[32*n +: 32]));
            w = av + s;
            if (st) begin
                if (pr == 2'b00) begin
                    if (w > 64'sh0FFFFFFFF) w = 64'sh0FFFFFFFF;
                end else begin
                    if (w > 64'sh07FFFFFFF) w = 64'sh07FFFFFFF;
                    if (w < -64'sh080000000) w = -64'sh080000000;
                end
            end
            r[32*n +: 32] = w[31:0];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request with downstream ready and check its result one cycle later.
    task automatic run_op(input string tag, input logic [1:0] pr, input logic st,
                          input logic [127:0] a, input logic [127:0] b,
                          input logic [127:0] acc, input logic [127:0] exp);
        @(negedge clk);
        op_pair = pr; op_sat = st; src_a = a; src_b = b; acc_in = acc;
        req_valid = 1'b1; res_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R9 valid"}, {127'd0, res_valid}, 128'd1);
        check(tag, res_data, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 reset valid", {127'd0, res_valid}, 128'd0);
        check("R11 reset data", res_data, 128'd0);
        check("R10 ready after reset", {127'd0, req_ready}, 128'd1);
        rst_n = 1'b1;
    endtask

    task automatic t_lane_map();
        logic [127:0] a, b;
        a = '0; b = '0;
        a[64 +: 8] = 8'd3; b[64 +: 8] = 8'd5;
        run_op("R1 lane map", 2'b10, 1'b0, a, b, '0, 128'h00000000_0000000F_00000000_00000000);
        a = 128'h01010101_02020202_03030303_04040404;
        b = 128'h01010101_01010101_01010101_01010101;
        run_op("R1 lane sums", 2'b00, 1'b0, a, b, 128'h10_00000020_00000030_00000040,
               128'h00000014_00000028_0000003C_00000050);
    endtask

    task automatic t_pairings();
        logic [127:0] ff, m80;
        ff  = {16{8'hFF}};
        m80 = {16{8'h80}};
        run_op("R2 uu ff*ff", 2'b00, 1'b0, ff, ff, '0, {4{32'h0003F804}});
        run_op("R3 us ff*80", 2'b01, 1'b0, ff, m80, '0, {4{32'hFFFE0200}});
        run_op("R4 ss ff*ff", 2'b10, 1'b0, ff, ff, '0, {4{32'h00000004}});
        run_op("R5 su ff*ff", 2'b11, 1'b0, ff, ff, '0, {4{32'hFFFFFC04}});
        run_op("R4 ss 80*80", 2'b10, 1'b0, m80, m80, '0, {4{32'h00010000}});
    endtask

    task automatic t_bounds();
        logic [127:0] ff, m80, m7f;
        ff  = {16{8'hFF}};
        m80 = {16{8'h80}};
        m7f = {16{8'h7F}};
        run_op("R6 ss wrap high", 2'b10, 1'b0, m80, m80, {4{32'h7FFFFFFF}}, {4{32'h8000FFFF}});
        run_op("R7 ss clamp high", 2'b10, 1'b1, m80, m80, {4{32'h7FFFFFFF}}, {4{32'h7FFFFFFF}});
        run_op("R7 ss clamp low", 2'b10, 1'b1, m80, m7f, {4{32'h80000005}}, {4{32'h80000000}});
        run_op("R6 ss wrap low", 2'b10, 1'b0, m80, m7f, {4{32'h80000005}}, {4{32'h7FFF0205}});
        run_op("R8 uu ceiling", 2'b00, 1'b1, ff, ff, {4{32'hFFFFFFF0}}, {4{32'hFFFFFFFF}});
        run_op("R6 uu wrap", 2'b00, 1'b0, ff, ff, {4{32'hFFFFFFF0}}, {4{32'h0003F7F4}});
        run_op("R7 us clamp low", 2'b01, 1'b1, ff, m80, {4{32'h80000001}}, {4{32'h80000000}});
        run_op("R8 uu no clamp below top", 2'b00, 1'b1, ff, ff, {4{32'h10}}, {4{32'h0003F814}});
    endtask

    // Every pairing in both flavours against the reference, several patterns.
    task automatic t_sweep();
        logic [127:0] pa [4];
        logic [127:0] pb [4];
        logic [127:0] pc [4];
        pa[0] = 128'h80FF7F01_00807FFF_12345678_9ABCDEF0;
        pb[0] = 128'hFF80017F_7F80FF00_87654321_0FEDCBA9;
        pc[0] = 128'h7FFFFFF0_80000005_FFFFFFF0_00000000;
        pa[1] = {16{8'h80}}; pb[1] = {16{8'hFF}}; pc[1] = 128'h80000000_7FFFFFFF_FFFFFFFF_00000001;
        pa[2] = {16{8'hFF}}; pb[2] = {16{8'h7F}}; pc[2] = 128'hFFFC0000_7FFF0000_80010000_0000FFFF;
        pa[3] = 128'h0102030405060708090A0B0C0D0E0F10;
        pb[3] = 128'hF0E0D0C0B0A090807060504030201000;
        pc[3] = 128'hDEADBEEF_CAFEF00D_00000000_7FFFFFFE;
        for (int p = 0; p < 4; p++) begin
            for (int op = 0; op < 8; op++) begin
                string tg;
                tg = $sformatf("R2 R3 R4 R5 R6 R7 R8 sweep p%0d op%0d", p, op);
                run_op(tg, op[1:0], op[2], pa[p], pb[p], pc[p],
                       ref_calc(op[1:0], op[2], pa[p], pb[p], pc[p]));
            end
        end
    endtask

    task automatic t_back_to_back();
        logic [127:0] e1, e2;
        e1 = ref_calc(2'b10, 1'b0, {16{8'h02}}, {16{8'h03}}, '0);
        e2 = ref_calc(2'b11, 1'b1, {16{8'hFE}}, {16{8'h90}}, {4{32'h80000010}});
        @(negedge clk);
        res_ready = 1'b1; req_valid = 1'b1;
        op_pair = 2'b10; op_sat = 1'b0; src_a = {16{8'h02}}; src_b = {16{8'h03}}; acc_in = '0;
        @(negedge clk);
        check("R12 first result", res_data, e1);
        check("R12 ready while draining", {127'd0, req_ready}, 128'd1);
        op_pair = 2'b11; op_sat = 1'b1; src_a = {16{8'hFE}}; src_b = {16{8'h90}};
        acc_in = {4{32'h80000010}};
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 second result", res_data, e2);
        check("R12 second valid", {127'd0, res_valid}, 128'd1);
        @(negedge clk);
        check("R9 valid drops when idle", {127'd0, res_valid}, 128'd0);
    endtask

    task automatic t_backpressure();
        logic [127:0] e1, e2;
        e1 = ref_calc(2'b00, 1'b0, {16{8'h11}}, {16{8'h22}}, '0);
        e2 = ref_calc(2'b01, 1'b0, {16{8'h33}}, {16{8'hC0}}, '0);
        @(negedge clk);
        res_ready = 1'b0; req_valid = 1'b1;
        op_pair = 2'b00; op_sat = 1'b0; src_a = {16{8'h11}}; src_b = {16{8'h22}}; acc_in = '0;
        @(negedge clk);
        check("R10 not ready when full", {127'd0, req_ready}, 128'd0);
        op_pair = 2'b01; src_a = {16{8'h33}}; src_b = {16{8'hC0}};
        repeat (2) @(negedge clk);
        check("R10 held data", res_data, e1);
        check("R10 held valid", {127'd0, res_valid}, 128'd1);
        res_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 pending request taken after drain", res_data, e2);
    endtask

    task automatic t_mid_reset();
        run_op("R9 before reset", 2'b00, 1'b0, {16{8'h01}}, {16{8'h01}}, '0, {4{32'h4}});
        @(negedge clk);
        req_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 mid reset valid", {127'd0, res_valid}, 128'd0);
        check("R11 mid reset data", res_data, 128'd0);
        rst_n = 1'b1;
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_lane_map();
        t_pairings();
        t_bounds();
        t_sweep();
        t_back_to_back();
        t_backpressure();
        t_mid_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule